// File: doc/BRIEF.md
# Hardware A20 Gate Command Decoder

This block drives the A20 gate line straight from host-side writes, with no local firmware or interrupt service in the path. It watches the write strobe, the channel number, the command/data select and the 8-bit write byte coming from the host bus decoder. Only writes aimed at one designated channel are decoded. A command write carrying the gate-control code arms the block. The data write that follows then copies its bit 1 onto the gate line.

An enable input switches the function on. While the enable is low, the gate is held at logic 1 and every write is ignored. A status output mirrors the gate for local readback. The gate register, the armed flag and the write classifier are separate pieces, and the events that pass between them are named wires.

Top module: `a20_fastgate`

## Requirements
- R1: After reset the gate output is 1 and no command is pending.
- R2: A command write (select = 1) of byte 0xD1 on the designated channel arms the block. The next data write (select = 0) on that channel sets the gate to bit 1 of its byte. The gate changes at the same clock edge that samples the strobe, so it is visible after that edge.
- R3: A data write that does not follow an armed 0xD1 command leaves the gate unchanged.
- R4: A command write of any byte other than 0xD1 disarms the block. A further 0xD1 command while armed keeps it armed.
- R5: The data write that follows an armed command also disarms the block, so each 0xD1 command updates the gate at most once.
- R6: Writes whose channel number differs from the designated channel change neither the gate nor the armed state.
- R7: While the enable is 0, the gate is forced to 1, writes are ignored and the armed state is cleared. After the enable rises, the gate remains 1 until a new command and data pair arrives.
- R8: The status output always equals the gate output.
- R9: Only bit 1 of the data byte decides the gate value. All other bits of the data byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Enable for the hardware gate path |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_chan | input | CHAN_W | Channel number of the write |
| wr_is_cmd | input | 1 | 1 = command write, 0 = data write |
| wr_byte | input | 8 | Write data byte |
| gate_out | output | 1 | A20 gate line |
| gate_status | output | 1 | Readback copy of the gate |

## Verification
The bench builds the block with a 2-bit channel field and the designated channel set to 2, not the default. This leaves three foreign channels to test, including channel 1, which would wrongly match if the designated channel were hard-wired. The test cases use 0xD1 sent as data, the byte 0xFD (bit 1 clear, all other bits set), back-to-back commands, and an armed command that survives a foreign-channel write. The bench also pulses the enable between a command and its data to confirm that the command is lost.

// File: rtl/a20_pkg.sv
package a20_pkg;

  typedef enum logic [1:0] {
    WR_NONE      = 2'd0,
    WR_GATE_CMD  = 2'd1,
    WR_OTHER_CMD = 2'd2,
    WR_DATA      = 2'd3
  } wr_class_e;

  // True when a command byte is the gate-control code
  function automatic logic is_gate_code(input logic [7:0] b, input logic [7:0] code);
    return b == code;
  endfunction

  // Gate level carried by a data byte
  function automatic logic gate_from_byte(input logic [7:0] b, input int unsigned bit_idx);
    return b[bit_idx];
  endfunction

endpackage

// File: rtl/a20_write_filter.sv
module a20_write_filter
  import a20_pkg::*;
#(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned GATE_CHAN = 1,
  parameter logic [7:0]  CMD_CODE  = 8'hD1
) (
  input  logic              en,
  input  logic              stb,
  input  logic [CHAN_W-1:0] chan,
  input  logic              is_cmd,
  input  logic [7:0]        data,
  output wr_class_e         cls
);
  localparam logic [CHAN_W-1:0] MY_CHAN = CHAN_W'(GATE_CHAN);

  logic on_chan;
  assign on_chan = en && stb && (chan == MY_CHAN);

  always_comb begin
    cls = WR_NONE;
    if (on_chan) begin
      if (!is_cmd)                          cls = WR_DATA;
      else if (is_gate_code(data, CMD_CODE)) cls = WR_GATE_CMD;
      else                                  cls = WR_OTHER_CMD;
    end
  end
endmodule

// File: rtl/a20_arm_tracker.sv
module a20_arm_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ev_gate_cmd,
  input  logic ev_other_cmd,
  input  logic ev_data,
  output logic armed,
  output logic consume
);
  assign consume = armed && ev_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                       armed <= 1'b0;
    else if (!en)                     armed <= 1'b0;
    else if (ev_gate_cmd)             armed <= 1'b1;
    else if (ev_other_cmd || ev_data) armed <= 1'b0;
  end

  // R4: gate command leaves the block armed
  a_r4_arm_on_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gate_cmd |=> armed);
  // R4: other command disarms
  a_r4_other_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    ev_other_cmd |=> !armed);
  // R5: a data write always leaves the block disarmed
  a_r5_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> !armed);
  // R7: disable clears pending command
  a_r7_disable_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed);
endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic load_val,
  output logic gate_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    gate_q <= 1'b1;
    else if (!en)  gate_q <= 1'b1;
    else if (load) gate_q <= load_val;
  end

  // R7: disabled gate reads high
  a_r7_forced_high: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> gate_q);
  // R2: loaded value appears after the sampling edge
  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> (gate_q == $past(load_val)));
  // R3: without a load the gate holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> $stable(gate_q));
endmodule

// File: rtl/a20_fastgate.sv
module a20_fastgate
  import a20_pkg::*;
#(
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned GATE_CHAN = 1,
  parameter logic [7:0]  CMD_CODE  = 8'hD1,
  parameter int unsigned GATE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              wr_stb,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_is_cmd,
  input  logic [7:0]        wr_byte,
  output logic              gate_out,
  output logic              gate_status
);
  localparam logic [CHAN_W-1:0] MY_CHAN = CHAN_W'(GATE_CHAN);

  wr_class_e cls;
  logic ev_gate_cmd, ev_other_cmd, ev_data;
  logic armed, consume, load_val, gate_q;

  a20_write_filter #(
    .CHAN_W(CHAN_W), .GATE_CHAN(GATE_CHAN), .CMD_CODE(CMD_CODE)
  ) filt_i (
    .en(gate_en), .stb(wr_stb), .chan(wr_chan),
    .is_cmd(wr_is_cmd), .data(wr_byte), .cls(cls)
  );

  assign ev_gate_cmd  = (cls == WR_GATE_CMD);
  assign ev_other_cmd = (cls == WR_OTHER_CMD);
  assign ev_data      = (cls == WR_DATA);
  assign load_val     = gate_from_byte(wr_byte, GATE_BIT);

  a20_arm_tracker arm_i (
    .clk(clk), .rst_n(rst_n), .en(gate_en),
    .ev_gate_cmd(ev_gate_cmd), .ev_other_cmd(ev_other_cmd), .ev_data(ev_data),
    .armed(armed), .consume(consume)
  );

  a20_gate_reg gate_i (
    .clk(clk), .rst_n(rst_n), .en(gate_en),
    .load(consume), .load_val(load_val), .gate_q(gate_q)
  );

  assign gate_out    = gate_q;
  assign gate_status = gate_q;

  // R6: writes on foreign channels leave the gate alone
  a_r6_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && wr_stb && (wr_chan != MY_CHAN)) |=> $stable(gate_out));
  // R1: first cycle after reset shows a high gate
  a_r1_reset_high: assert property (@(posedge clk)
    !rst_n |=> gate_out);
endmodule

// File: tb/a20_fastgate_tb.sv
module a20_fastgate_tb_top;
  localparam int unsigned CW = 2;
  localparam int unsigned GC = 2;

  typedef struct {
    logic  exp_gate;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b0;
  logic wr_stb = 1'b0;
  logic [CW-1:0] wr_chan = '0;
  logic wr_is_cmd = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic gate_out, gate_status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  item_t q[$];

  logic m_gate = 1'b1;
  logic m_armed = 1'b0;
  logic m_en = 1'b0;

  always #5 clk = ~clk;

  a20_fastgate #(.CHAN_W(CW), .GATE_CHAN(GC)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .wr_stb(wr_stb),
    .wr_chan(wr_chan), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
    .gate_out(gate_out), .gate_status(gate_status)
  );

  task automatic push(input string tag);
    item_t it;
    it.exp_gate = m_gate;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input int ch, input bit cmd, input logic [7:0] b, input string tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_chan = CW'(ch); wr_is_cmd = cmd; wr_byte = b;
    @(negedge clk);
    wr_stb = 1'b0;
    if (m_en && ch == GC) begin
      if (cmd) m_armed = (b == 8'hD1);
      else begin
        if (m_armed) m_gate = b[1];
        m_armed = 1'b0;
      end
    end
    push(tag);
  endtask

  task automatic set_en(input bit v, input string tag);
    @(negedge clk);
    gate_en = v;
    @(negedge clk);
    m_en = v;
    if (!v) begin m_gate = 1'b1; m_armed = 1'b0; end
    push(tag);
  endtask

  // monitor: compare after the driver has pushed at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (gate_out !== it.exp_gate || gate_status !== it.exp_gate) begin
          n_bad++;
          $display("FAIL %s: gate_out=%b gate_status=%b expected=%b",
                   it.tag, gate_out, gate_status, it.exp_gate);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 reset value");
    set_en(1'b1, "R1 enabled after reset");
    wr(GC, 1'b0, 8'h00, "R1 no pending command after reset");
    wr(GC, 1'b1, 8'hD1, "R2 arm does not move gate");
    wr(GC, 1'b0, 8'h00, "R2 clear via bit1=0");
    wr(GC, 1'b0, 8'h02, "R3 R5 unarmed data ignored");
    wr(GC, 1'b1, 8'hD1, "R2 arm");
    wr(GC, 1'b0, 8'h02, "R2 set via bit1=1");
    wr(GC, 1'b1, 8'hD1, "R9 arm");
    wr(GC, 1'b0, 8'hFD, "R9 other bits set, bit1 clear");
    wr(GC, 1'b1, 8'hD1, "R9 arm");
    wr(GC, 1'b0, 8'h02, "R9 only bit1 set");
    wr(GC, 1'b1, 8'hD1, "R4 arm");
    wr(GC, 1'b1, 8'hD1, "R4 rearm");
    wr(GC, 1'b0, 8'h00, "R4 rearmed data applies");
    wr(GC, 1'b1, 8'hD1, "R4 arm");
    wr(GC, 1'b1, 8'h60, "R4 other command");
    wr(GC, 1'b0, 8'h02, "R4 disarmed data ignored");
    wr(GC, 1'b0, 8'hD1, "R4 0xD1 as data does not arm");
    wr(GC, 1'b0, 8'h02, "R4 still unarmed");
    wr(1,  1'b1, 8'hD1, "R6 foreign command");
    wr(GC, 1'b0, 8'h02, "R6 foreign command did not arm");
    wr(GC, 1'b1, 8'hD1, "R6 arm");
    wr(0,  1'b0, 8'h02, "R6 foreign data ignored");
    wr(3,  1'b1, 8'h60, "R6 foreign command ignored");
    wr(GC, 1'b0, 8'h02, "R6 armed state survived");
    wr(GC, 1'b1, 8'hD1, "R5 arm");
    wr(GC, 1'b0, 8'h00, "R5 clear");
    wr(GC, 1'b0, 8'h02, "R5 second data ignored");
    set_en(1'b0, "R7 disable forces high");
    wr(GC, 1'b1, 8'hD1, "R7 command while disabled");
    wr(GC, 1'b0, 8'h00, "R7 data while disabled");
    set_en(1'b1, "R7 re-enable high");
    wr(GC, 1'b0, 8'h00, "R7 no stale arm");
    wr(GC, 1'b1, 8'hD1, "R7 arm");
    set_en(1'b0, "R7 disable between command and data");
    set_en(1'b1, "R7 re-enable");
    wr(GC, 1'b0, 8'h00, "R7 command lost by disable");
    wr(GC, 1'b1, 8'hD1, "R8 arm");
    wr(GC, 1'b0, 8'h00, "R8 status tracks low");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule